// File: doc/BRIEF.md
# SPI Register Interface With Command Decode

This block is the serial register port of a multichannel phase driver. An external controller reaches the internal register file over a four-wire SPI link: chip select (active low), serial clock, data in and data out. Every transfer begins with an opcode byte. A read or write opcode is followed by a byte count, then a start address, then a burst of data bytes. The register address steps up by one after each data byte. A typical refresh writes both data banks in one transfer of 128 data bytes.

A four-byte unlock signature, sent as the first bytes of a transfer, opens a hidden register window. That window stays open until chip select returns high. The block also tracks two "waiting for data" flags, one for the normal data bank and one for the overdrive data bank. Writing the final address of a bank clears that bank's flag. Once the flags required by the overdrive setting are cleared, the block emits a fixed-length data-ready pulse and sets both flags again.

All serial inputs are oversampled in the system clock domain. The serial clock idles low, and each of its half periods must last at least eight system clock cycles.

Top module: `spiRegIf`

## Requirements
- R1: After reset, `dout`, `doutOe`, `regWe`, `dataReady` and `hiddenMode` are all 0. `doutOe` is 1 while `csN` is low and 0 while it is high.
- R2: `din` is captured on each falling `sclk` edge, most significant bit first. `dout` presents a new bit, most significant first, after each rising `sclk` edge.
- R3: The write opcode 0x55 takes the form opcode, count N, start address A, then data bytes. For k < N, data byte k is written to address A+k with exactly one `regWe` cycle. Data bytes beyond the N-th write nothing.
- R4: The read opcode 0xAA uses the same framing. For k < N, the k-th byte after the address returns the register at A+k. Every later byte returns 0x00.
- R5: The address wraps from 0xFF to 0x00 during a burst.
- R6: Any opcode other than 0xAA, 0x55 or 0x5A makes the rest of the transfer write nothing and return 0x00 on `dout`.
- R7: The bytes 0x5A, 0xA5, 0x6F, 0xF6 sent as the first four bytes of a transfer set `hiddenMode`. The next byte is then decoded as an opcode, and all of that transfer's accesses carry `hiddenMode`=1.
- R8: `hiddenMode` clears when `csN` goes high. An unlock attempt whose sequence breaks leaves `hiddenMode` at 0 and ignores the rest of the transfer.
- R9: If `csN` rises partway through a byte, the partial byte is discarded and writes nothing. The next transfer starts again at the opcode.
- R10: Both bank flags are set after reset. A write with `hiddenMode`=0 to address NORM_LAST_ADDR (default 0x3F) clears the normal flag, and a write to OD_LAST_ADDR (default 0x7F) clears the overdrive flag. Hidden writes leave both flags unchanged.
- R11: With `overdriveEn`=0, `dataReady` fires once the normal flag is clear. With `overdriveEn`=1, both flags must be clear. Both flags are set again when the pulse starts.
- R12: Each `dataReady` pulse stays high for exactly PULSE_CYCLES clock cycles (default 500).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| din | input | 1 | Serial data from the controller |
| dout | output | 1 | Serial data to the controller |
| doutOe | output | 1 | Output enable for `dout`; 0 means high impedance |
| regAddr | output | 8 | Register address for reads and writes |
| regWe | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Register write data |
| regRdData | input | 8 | Register read data for `regAddr` |
| hiddenMode | output | 1 | Hidden register window selected |
| overdriveEn | input | 1 | Overdrive bank must also be written before data-ready |
| dataReady | output | 1 | Data-ready pulse |

## Verification
The hardest state to reach from the ports is a pair of bank flags that are half cleared and then carried across transfers. In that state, a write to one bank's final address must not raise `dataReady`, while a later write to the other bank's final address must. The stimulus gets there with a directed run of single-byte writes. These switch `overdriveEn` between transfers and first write the overdrive bank's final address, then the normal one's. A hidden-window write to the same address confirms the flags stay untouched. Bursts from a fixed-seed random source, with random counts and spare trailing bytes, are mixed with a mid-byte abort, a broken unlock and an address wrap.

// File: rtl/spiRegPkg.sv
package spiRegPkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_READ  = 8'hAA;
  localparam logic [BYTE_W-1:0] OP_WRITE = 8'h55;
  localparam logic [BYTE_W-1:0] KEY0     = 8'h5A;
  localparam logic [BYTE_W-1:0] KEY1     = 8'hA5;
  localparam logic [BYTE_W-1:0] KEY2     = 8'h6F;
  localparam logic [BYTE_W-1:0] KEY3     = 8'hF6;

  // strobes from the frame controller to the datapath
  typedef struct packed {
    logic loadCount;
    logic loadAddr;
    logic writeEn;
    logic loadTx;
  } ctrlStrobeT;

  typedef enum logic [3:0] {
    ST_OPC,
    ST_CNT,
    ST_ADR,
    ST_WR,
    ST_RPREP,
    ST_RD,
    ST_KEY1,
    ST_KEY2,
    ST_KEY3,
    ST_SKIP
  } frameStateT;

endpackage

// File: rtl/spiRegDatapath.sv
module spiRegDatapath
  import spiRegPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  input  ctrlStrobeT        strobe,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              csIdle,
  output logic              byteValid,
  output logic [BYTE_W-1:0] rxByte,
  output logic              remainZero,
  output logic [BYTE_W-1:0] regAddr,
  output logic              dout,
  output logic              doutOe
);

  localparam int SYNC_W    = 3 * SYNC_STAGES;
  localparam int BIT_CNT_W = $clog2(BYTE_W);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  logic [SYNC_W-1:0]    syncQ;
  logic                 sclkS, dinS, sclkQ;
  logic                 sclkFall, sclkRise;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0]    rxShift, txShift, addrQ, remainQ;

  // input synchronizer: {cs, sclk, din} per stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= {SYNC_STAGES{3'b100}};
      sclkQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_W-4:0], csN, sclk, din};
      sclkQ <= sclkS;
    end
  end

  assign csIdle   = syncQ[SYNC_W-1];
  assign sclkS    = syncQ[SYNC_W-2];
  assign dinS     = syncQ[SYNC_W-3];
  assign sclkFall = sclkQ & ~sclkS & ~csIdle;
  assign sclkRise = ~sclkQ & sclkS & ~csIdle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      byteValid <= 1'b0;
      rxShift   <= '0;
      txShift   <= '0;
      dout      <= 1'b0;
      addrQ     <= '0;
      remainQ   <= '0;
    end else if (csIdle) begin
      bitCnt    <= '0;
      byteValid <= 1'b0;
      txShift   <= '0;
      dout      <= 1'b0;
      remainQ   <= '0;
    end else begin
      byteValid <= 1'b0;
      if (sclkFall) begin
        rxShift <= {rxShift[BYTE_W-2:0], dinS};
        bitCnt  <= bitCnt + 1'b1;
        if (bitCnt == LAST_BIT) byteValid <= 1'b1;
      end
      if (sclkRise) begin
        dout    <= txShift[BYTE_W-1];
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
      end
      if (strobe.loadCount) remainQ <= rxShift;
      if (strobe.loadAddr)  addrQ   <= rxShift;
      if (strobe.writeEn) begin
        addrQ   <= addrQ + 1'b1;
        remainQ <= remainQ - 1'b1;
      end
      if (strobe.loadTx) begin
        if (remainZero) begin
          txShift <= '0;
        end else begin
          txShift <= regRdData;
          addrQ   <= addrQ + 1'b1;
          remainQ <= remainQ - 1'b1;
        end
      end
    end
  end

  assign rxByte     = rxShift;
  assign remainZero = (remainQ == '0);
  assign regAddr    = addrQ;
  assign doutOe     = ~csIdle;

  // R3
  write_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeEn |-> !remainZero);

  // R9
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    csIdle |=> (bitCnt == '0) && !byteValid);

endmodule

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIdle,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              remainZero,
  output ctrlStrobeT        strobe,
  output logic              hiddenMode
);

  frameStateT state, stateNext;
  logic       opRead, opReadNext, hiddenSet;

  always_comb begin
    stateNext  = state;
    opReadNext = opRead;
    strobe     = '0;
    hiddenSet  = 1'b0;
    unique case (state)
      ST_OPC: if (byteValid) begin
        if (rxByte == OP_READ) begin
          stateNext  = ST_CNT;
          opReadNext = 1'b1;
        end else if (rxByte == OP_WRITE) begin
          stateNext  = ST_CNT;
          opReadNext = 1'b0;
        end else if (rxByte == KEY0 && !hiddenMode) begin
          stateNext = ST_KEY1;
        end else begin
          stateNext = ST_SKIP;
        end
      end
      ST_CNT: if (byteValid) begin
        strobe.loadCount = 1'b1;
        stateNext        = ST_ADR;
      end
      ST_ADR: if (byteValid) begin
        strobe.loadAddr = 1'b1;
        stateNext       = opRead ? ST_RPREP : ST_WR;
      end
      ST_RPREP: begin
        strobe.loadTx = 1'b1;
        stateNext     = ST_RD;
      end
      ST_RD:  strobe.loadTx  = byteValid;
      ST_WR:  strobe.writeEn = byteValid && !remainZero;
      ST_KEY1: if (byteValid) stateNext = (rxByte == KEY1) ? ST_KEY2 : ST_SKIP;
      ST_KEY2: if (byteValid) stateNext = (rxByte == KEY2) ? ST_KEY3 : ST_SKIP;
      ST_KEY3: if (byteValid) begin
        if (rxByte == KEY3) begin
          hiddenSet = 1'b1;
          stateNext = ST_OPC;
        end else begin
          stateNext = ST_SKIP;
        end
      end
      default: stateNext = ST_SKIP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_OPC;
      opRead     <= 1'b0;
      hiddenMode <= 1'b0;
    end else if (csIdle) begin
      state      <= ST_OPC;
      opRead     <= 1'b0;
      hiddenMode <= 1'b0;
    end else begin
      state  <= stateNext;
      opRead <= opReadNext;
      if (hiddenSet) hiddenMode <= 1'b1;
    end
  end

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R7
  unlock_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hiddenMode) |-> $past(byteValid && rxByte == KEY3));

  // R8
  hidden_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    csIdle |=> !hiddenMode);

endmodule

// File: rtl/spiReadyGen.sv
module spiReadyGen
  import spiRegPkg::*;
#(
  parameter logic [BYTE_W-1:0] NORM_LAST_ADDR = 8'h3F,
  parameter logic [BYTE_W-1:0] OD_LAST_ADDR   = 8'h7F,
  parameter int                PULSE_CYCLES   = 500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [BYTE_W-1:0] regAddr,
  input  logic              hiddenMode,
  input  logic              overdriveEn,
  output logic              dataReady
);

  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES - 1);

  logic             normFlag, odFlag, busy, fire, normClr, odClr;
  logic [CNT_W-1:0] pulseCnt;

  assign normClr = regWe && !hiddenMode && (regAddr == NORM_LAST_ADDR);
  assign odClr   = regWe && !hiddenMode && (regAddr == OD_LAST_ADDR);
  assign fire    = !busy && !normFlag && (!odFlag || !overdriveEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      normFlag <= 1'b1;
      odFlag   <= 1'b1;
      busy     <= 1'b0;
      pulseCnt <= '0;
    end else begin
      if (fire) begin
        normFlag <= 1'b1;
        odFlag   <= 1'b1;
        busy     <= 1'b1;
        pulseCnt <= CNT_LOAD;
      end else if (busy) begin
        if (pulseCnt == '0) busy <= 1'b0;
        else pulseCnt <= pulseCnt - 1'b1;
      end
      if (normClr) normFlag <= 1'b0;
      if (odClr)   odFlag   <= 1'b0;
    end
  end

  assign dataReady = busy;

  // R12
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataReady) |-> $past(pulseCnt) == '0);

  // R11
  fire_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataReady) |-> $past(!normFlag && (!odFlag || !overdriveEn)));

endmodule

// File: rtl/spiRegIf.sv
module spiRegIf
  import spiRegPkg::*;
#(
  parameter int                SYNC_STAGES    = 2,
  parameter logic [BYTE_W-1:0] NORM_LAST_ADDR = 8'h3F,
  parameter logic [BYTE_W-1:0] OD_LAST_ADDR   = 8'h7F,
  parameter int                PULSE_CYCLES   = 500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              doutOe,
  output logic [BYTE_W-1:0] regAddr,
  output logic              regWe,
  output logic [BYTE_W-1:0] regWrData,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              hiddenMode,
  input  logic              overdriveEn,
  output logic              dataReady
);

  ctrlStrobeT        strobe;
  logic              csIdle, byteValid, remainZero;
  logic [BYTE_W-1:0] rxByte;

  spiRegDatapath #(.SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .strobe(strobe), .regRdData(regRdData),
    .csIdle(csIdle), .byteValid(byteValid), .rxByte(rxByte),
    .remainZero(remainZero), .regAddr(regAddr),
    .dout(dout), .doutOe(doutOe)
  );

  spiRegCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .csIdle(csIdle), .byteValid(byteValid),
    .rxByte(rxByte), .remainZero(remainZero),
    .strobe(strobe), .hiddenMode(hiddenMode)
  );

  spiReadyGen #(
    .NORM_LAST_ADDR(NORM_LAST_ADDR),
    .OD_LAST_ADDR(OD_LAST_ADDR),
    .PULSE_CYCLES(PULSE_CYCLES)
  ) i_ready (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .hiddenMode(hiddenMode), .overdriveEn(overdriveEn),
    .dataReady(dataReady)
  );

  assign regWe     = strobe.writeEn;
  assign regWrData = rxByte;

endmodule

// File: tb/test_spiRegIf.sv
module test_spiRegIf;

  localparam int PULSE = 500;
  localparam int HP    = 8;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, din = 1'b0;
  logic overdriveEn = 1'b0;
  logic dout, doutOe, regWe, hiddenMode, dataReady;
  logic [7:0] regAddr, regWrData, regRdData;

  logic [7:0] mem    [2][256];
  logic [7:0] expMem [2][256];
  logic [7:0] buffer [32];

  int errors = 0, checks = 0, wrCount = 0;
  int readyRises = 0, curW = 0, lastW = 0;
  logic prevReady = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign regRdData = mem[hiddenMode][regAddr];

  spiRegIf #(.PULSE_CYCLES(PULSE)) i_spiRegIf (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .dout(dout), .doutOe(doutOe), .regAddr(regAddr), .regWe(regWe),
    .regWrData(regWrData), .regRdData(regRdData), .hiddenMode(hiddenMode),
    .overdriveEn(overdriveEn), .dataReady(dataReady)
  );

  // register file model and ready pulse monitor
  always @(negedge clk) begin
    if (rstN && regWe) begin
      mem[hiddenMode][regAddr] = regWrData;
      wrCount++;
    end
    if (dataReady) curW++;
    if (dataReady && !prevReady) readyRises++;
    if (!dataReady && prevReady) begin
      lastW = curW;
      curW  = 0;
    end
    prevReady = dataReady;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiByte(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      din  = tx[7-i];
      sclk = 1'b1;
      waitClk(HP);
      rx[7-i] = dout;
      sclk = 1'b0;
      waitClk(HP);
    end
  endtask

  task automatic csLow();
    @(negedge clk);
    csN = 1'b0;
    waitClk(HP);
  endtask

  task automatic csHigh();
    waitClk(HP);
    csN = 1'b1;
    waitClk(HP);
  endtask

  task automatic checkMems(input string req);
    int bad = 0, badIdx = 0, badBank = 0;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 256; i++)
        if (mem[b][i] !== expMem[b][i] && bad == 0) begin
          bad = 1; badIdx = i; badBank = b;
        end
    check(bad == 0, req, $sformatf("register bank %0d addr %0h", badBank, badIdx),
          int'(mem[badBank][badIdx]), int'(expMem[badBank][badIdx]));
  endtask

  // one framed transfer; expected values come from the bench model
  task automatic xfer(input bit unlock, input logic [7:0] op, input logic [7:0] n,
                      input logic [7:0] a, input int nData, input int abortBits,
                      input string req);
    logic [7:0] rx, idx;
    csLow();
    check(doutOe === 1'b1, "R1", "doutOe while selected", int'(doutOe), 1);
    if (unlock) begin
      spiByte(8'h5A, 8, rx); spiByte(8'hA5, 8, rx);
      spiByte(8'h6F, 8, rx); spiByte(8'hF6, 8, rx);
      check(hiddenMode === 1'b1, "R7", "hiddenMode after unlock", int'(hiddenMode), 1);
    end
    spiByte(op, 8, rx); spiByte(n, 8, rx); spiByte(a, 8, rx);
    for (int k = 0; k < nData; k++) begin
      idx = a + 8'(k);
      if (op == 8'h55) begin
        spiByte(buffer[k], 8, rx);
        if (k < int'(n)) expMem[unlock][idx] = buffer[k];
      end else if (op == 8'hAA) begin
        spiByte(8'h00, 8, rx);
        check(rx === ((k < int'(n)) ? expMem[unlock][idx] : 8'h00), req,
              $sformatf("read byte %0d", k), int'(rx),
              int'((k < int'(n)) ? expMem[unlock][idx] : 8'h00));
      end else begin
        spiByte(buffer[k], 8, rx);
        check(rx === 8'h00, req, "dout after unknown opcode", int'(rx), 0);
      end
    end
    if (abortBits > 0) spiByte(8'hFF, abortBits, rx);
    csHigh();
    check(doutOe === 1'b0, "R1", "doutOe after deselect", int'(doutOe), 0);
    if (unlock)
      check(hiddenMode === 1'b0, "R8", "hiddenMode after deselect", int'(hiddenMode), 0);
  endtask

  task automatic readyWrite(input bit unlock, input logic [7:0] addr, input bit od,
                            input bit expectPulse, input string req);
    int r0;
    overdriveEn = od;
    r0 = readyRises;
    buffer[0] = 8'($urandom);
    xfer(unlock, 8'h55, 8'd1, addr, 1, 0, req);
    waitClk(PULSE + 40);
    check(readyRises == r0 + int'(expectPulse), req,
          $sformatf("data-ready pulses after write to %0h", addr),
          readyRises - r0, int'(expectPulse));
    if (expectPulse)
      check(lastW == PULSE, "R12", "data-ready width", lastW, PULSE);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    int w0;
    logic [7:0] rx, n, a;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) begin
      mem[0][i] = 8'($urandom); mem[1][i] = 8'($urandom);
      expMem[0][i] = mem[0][i]; expMem[1][i] = mem[1][i];
    end

    // R1: reset state
    waitClk(5);
    check(dataReady === 1'b0 && hiddenMode === 1'b0 && regWe === 1'b0, "R1",
          "strobes in reset", int'({dataReady, hiddenMode, regWe}), 0);
    rstN = 1'b1;
    waitClk(4);
    check(dout === 1'b0 && doutOe === 1'b0, "R1", "dout/doutOe idle",
          int'({dout, doutOe}), 0);

    // R2 R3: directed burst write
    for (int k = 0; k < 4; k++) buffer[k] = 8'h81 + 8'(k * 17);
    xfer(0, 8'h55, 8'd4, 8'h90, 4, 0, "R3");
    checkMems("R3");

    // R3: bytes past the count write nothing
    w0 = wrCount;
    for (int k = 0; k < 4; k++) buffer[k] = 8'($urandom);
    xfer(0, 8'h55, 8'd2, 8'hA0, 4, 0, "R3");
    check(wrCount == w0 + 2, "R3", "write strobes for count 2", wrCount - w0, 2);
    checkMems("R3");

    // R2 R4: burst read with trailing bytes
    xfer(0, 8'hAA, 8'd5, 8'h90, 7, 0, "R4");

    // R5: wrap through 0xFF
    for (int k = 0; k < 4; k++) buffer[k] = 8'hC4 + 8'(k);
    xfer(0, 8'h55, 8'd4, 8'hFE, 4, 0, "R5");
    xfer(0, 8'hAA, 8'd4, 8'hFE, 4, 0, "R5");
    checkMems("R5");

    // R6: unknown opcode
    w0 = wrCount;
    xfer(0, 8'h33, 8'd1, 8'hB0, 3, 0, "R6");
    check(wrCount == w0, "R6", "writes after unknown opcode", wrCount - w0, 0);

    // R8: broken unlock sequence
    w0 = wrCount;
    csLow();
    spiByte(8'h5A, 8, rx); spiByte(8'hA5, 8, rx); spiByte(8'h00, 8, rx);
    check(hiddenMode === 1'b0, "R8", "hiddenMode after broken unlock", int'(hiddenMode), 0);
    spiByte(8'h55, 8, rx); spiByte(8'h01, 8, rx); spiByte(8'hB4, 8, rx);
    spiByte(8'h77, 8, rx);
    csHigh();
    check(wrCount == w0, "R8", "writes after broken unlock", wrCount - w0, 0);

    // R7: hidden window write and read, main bank untouched
    for (int k = 0; k < 3; k++) buffer[k] = 8'h3C + 8'(k);
    xfer(1, 8'h55, 8'd3, 8'h10, 3, 0, "R7");
    xfer(1, 8'hAA, 8'd3, 8'h10, 3, 0, "R7");
    xfer(0, 8'hAA, 8'd3, 8'h10, 3, 0, "R7");
    checkMems("R7");

    // R9: abort partway through a byte
    w0 = wrCount;
    buffer[0] = 8'h6A;
    xfer(0, 8'h55, 8'd3, 8'hC0, 1, 5, "R9");
    check(wrCount == w0 + 1, "R9", "writes with aborted byte", wrCount - w0, 1);
    xfer(0, 8'hAA, 8'd2, 8'hC0, 2, 0, "R9");
    checkMems("R9");

    // R10 R11 R12: bank flag sequence
    readyWrite(1, 8'h3F, 0, 0, "R10");
    readyWrite(0, 8'h3F, 0, 1, "R11");
    readyWrite(0, 8'h3F, 1, 0, "R11");
    readyWrite(0, 8'h7F, 1, 1, "R11");
    readyWrite(0, 8'h7F, 1, 0, "R10");
    readyWrite(0, 8'h3F, 1, 1, "R11");
    overdriveEn = 1'b0;

    // R3 R4: random bursts
    for (int t = 0; t < 12; t++) begin
      n = 8'(1 + $urandom % 10);
      a = 8'(8'h80 + $urandom % 8'h70);
      for (int k = 0; k < 16; k++) buffer[k] = 8'($urandom);
      if ($urandom % 2 == 0)
        xfer(0, 8'h55, n, a, int'(n) + int'($urandom % 3), 0, "R3");
      else
        xfer(0, 8'hAA, n, a, int'(n) + int'($urandom % 3), 0, "R4");
    end
    checkMems("R3");

    done = 1'b1;
    finishRun();
  end

endmodule